// File: doc/BRIEF.md
# OR-Dispatch Next-Address Sequencer with Page-Cross Trap

This block forms the address of the next microinstruction in a small microcoded engine. Every microword supplies a base next address. Branches never pick between two targets. Instead, condition bits are ORed into the low end of that base. A zero-test branch sets bit 0 when the current ALU result is zero. A two-bit external dispatch ORs its status into bits 1:0. Microcode therefore places branch and dispatch targets at bases whose low bits are clear, and the condition bits then land on consecutive entries. A four-way table based at binary 1100 reaches entries 1100 to 1111.

A page here is 256 words. When an instruction loads the memory address register from an ALU result that carries out of bit 7, the block arms a page-cross trap. In the instruction that follows, any memory access is aborted, and bit 1 is ORed into the next address that instruction computes. This OR combines with any dispatch or zero bit of that same instruction. The trap lasts exactly one instruction.

The trap is a two-state machine. `PG_IDLE` means no crossing is pending. `PG_ARMED` means the previous instruction crossed a page. The transition `IDLE_TO_ARMED` fires on a page-crossing load. `ARMED_TO_ARMED` fires when the armed instruction itself crosses again. `ARMED_TO_IDLE` fires on every other instruction, and `IDLE_HOLD` covers the rest. One instruction is issued per clock. The next address is registered and resets to 0.

Top module: `ums_microseq`

## Requirements
- R1: With branch select 00 (none) and no trap armed, the registered next address one clock later equals the microword's base field exactly, whatever the ALU zero flag and dispatch status are.
- R2: With branch select 01 (zero test), the next address is base OR 1 when the ALU zero flag is 1, and the base unchanged when the flag is 0.
- R3: With branch select 10 (dispatch), bits 1:0 of the next address are the base bits ORed with the two dispatch status bits, and bits 11:2 keep the base. Base 0x00C gives 0x00C to 0x00F for status 0 to 3.
- R4: An instruction with both address-register load and ALU carry-out of bit 7 arms the trap. In the immediately following instruction, abort_mem is 1 while that instruction requests memory.
- R5: The instruction that follows a page crossing gets bit 1 (value 2) ORed into its next address, together with its own zero or dispatch bits.
- R6: The trap clears after one instruction. The instruction after the trapped one sees no abort and no OR of 2, unless the trapped instruction crossed a page again.
- R7: The page-crossing instruction's own next address is not modified by its crossing.
- R8: While reset is active, next_addr is 0 and abort_mem is 0. A crossing pending at reset is discarded.
- R9: Branch select 11 is reserved and acts as none.
- R10: An address-register load without carry, or a carry without an address-register load, does not arm the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_field | input | 12 | Base next address from the microword |
| br_sel | input | 2 | 00 none, 01 zero test, 10 dispatch, 11 reserved |
| alu_zero | input | 1 | ALU result of this instruction is zero |
| disp_status | input | 2 | External dispatch status |
| mar_load | input | 1 | This instruction loads the address register from the ALU |
| alu_carry8 | input | 1 | ALU carry out of bit 7 |
| mem_req | input | 1 | This instruction requests a memory access |
| next_addr | output | 12 | Registered next microinstruction address |
| abort_mem | output | 1 | Suppress this instruction's memory access |

## Verification
Two functions can hit the same instruction. The page-cross OR may coincide with a dispatch or zero-test OR, and a trapped instruction may itself cross a page again. The bench arms a crossing and then issues a dispatch or zero-test instruction. It expects bit 1 from the trap merged with the instruction's own condition bits, for example 0x013 from base 0x010 with status 01. It also runs back-to-back crossings. Each trapped instruction must show abort_mem and the OR of 2, and the trap must drop one instruction after the last crossing.

// File: rtl/ums_pkg.sv
package ums_pkg;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_ZERO = 2'b01,
        BR_DISP = 2'b10,
        BR_RSVD = 2'b11
    } br_sel_e;

    typedef enum logic {
        PG_IDLE  = 1'b0,
        PG_ARMED = 1'b1
    } pg_state_e;

endpackage

// File: rtl/ums_cond_or.sv
module ums_cond_or
    import ums_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DISP_W = 2
) (
    input  logic [1:0]        br_sel,
    input  logic              alu_zero,
    input  logic [DISP_W-1:0] disp_status,
    output logic [ADDR_W-1:0] cond_mask
);
    localparam int PAD_W = ADDR_W - DISP_W;
    localparam logic [ADDR_W-1:0] ZERO_BIT = ADDR_W'(1);

    br_sel_e sel;

    always_comb begin
        sel = br_sel_e'(br_sel);
        unique case (sel)
            BR_NONE: cond_mask = '0;
            BR_ZERO: cond_mask = alu_zero ? ZERO_BIT : '0;
            BR_DISP: cond_mask = {{PAD_W{1'b0}}, disp_status};
            BR_RSVD: cond_mask = '0;
            default: cond_mask = '0;
        endcase
    end

    // R9: the reserved select contributes nothing
    always_comb begin
        if (br_sel == 2'b11) begin
            a_r9_rsvd_quiet: assert (cond_mask == '0 || $isunknown(cond_mask));
        end
    end

endmodule

// File: rtl/ums_page_trap.sv
module ums_page_trap
    import ums_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PCROSS_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mar_load,
    input  logic              alu_carry8,
    input  logic              mem_req,
    output logic              abort_mem,
    output logic              pg_armed,
    output logic [ADDR_W-1:0] pg_mask
);
    localparam logic [ADDR_W-1:0] PC_BIT_MASK = ADDR_W'(1) << PCROSS_BIT;

    pg_state_e state, state_nxt;
    logic      crossing;

    assign crossing = mar_load & alu_carry8;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PG_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions: IDLE_HOLD, IDLE_TO_ARMED, ARMED_TO_ARMED, ARMED_TO_IDLE
    always_comb begin
        unique case (state)
            PG_IDLE:  state_nxt = crossing ? PG_ARMED : PG_IDLE;
            PG_ARMED: state_nxt = crossing ? PG_ARMED : PG_IDLE;
            default:  state_nxt = PG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            PG_ARMED: begin
                pg_armed  = 1'b1;
                abort_mem = mem_req;
                pg_mask   = PC_BIT_MASK;
            end
            default: begin
                pg_armed  = 1'b0;
                abort_mem = 1'b0;
                pg_mask   = '0;
            end
        endcase
    end

    // R4: a crossing aborts the following instruction's memory request
    a_r4_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mar_load && alu_carry8) && mem_req) |-> abort_mem);

    // R6 / R10: without a crossing in the previous instruction nothing is trapped
    a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mar_load && alu_carry8)) |-> (!abort_mem && pg_mask == '0));

endmodule

// File: rtl/ums_addr_reg.sv
module ums_addr_reg #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_field,
    input  logic [ADDR_W-1:0] cond_mask,
    input  logic [ADDR_W-1:0] pg_mask,
    output logic [ADDR_W-1:0] next_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_addr <= '0;
        end else begin
            next_addr <= base_field | cond_mask | pg_mask;
        end
    end

    // R8: reset forces address zero
    a_r8_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (next_addr == '0));

endmodule

// File: rtl/ums_microseq.sv
module ums_microseq
    import ums_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DISP_W     = 2,
    parameter int PCROSS_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] next_field,
    input  logic [1:0]        br_sel,
    input  logic              alu_zero,
    input  logic [DISP_W-1:0] disp_status,
    input  logic              mar_load,
    input  logic              alu_carry8,
    input  logic              mem_req,
    output logic [ADDR_W-1:0] next_addr,
    output logic              abort_mem
);
    logic [ADDR_W-1:0] cond_mask;
    logic [ADDR_W-1:0] pg_mask;
    logic              pg_armed;

    ums_cond_or #(
        .ADDR_W(ADDR_W),
        .DISP_W(DISP_W)
    ) u_cond (
        .br_sel      (br_sel),
        .alu_zero    (alu_zero),
        .disp_status (disp_status),
        .cond_mask   (cond_mask)
    );

    ums_page_trap #(
        .ADDR_W    (ADDR_W),
        .PCROSS_BIT(PCROSS_BIT)
    ) u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .mar_load   (mar_load),
        .alu_carry8 (alu_carry8),
        .mem_req    (mem_req),
        .abort_mem  (abort_mem),
        .pg_armed   (pg_armed),
        .pg_mask    (pg_mask)
    );

    ums_addr_reg #(
        .ADDR_W(ADDR_W)
    ) u_areg (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_field (next_field),
        .cond_mask  (cond_mask),
        .pg_mask    (pg_mask),
        .next_addr  (next_addr)
    );

    // R1: plain sequencing passes the base through
    a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_sel) == 2'b00 && !$past(pg_armed))
        |-> (next_addr == $past(next_field)));

    // R2: zero test sets bit 0
    a_r2_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_sel) == 2'b01 && $past(alu_zero)) |-> next_addr[0]);

    // R3: every dispatch status bit appears in the low bits
    a_r3_disp_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_sel) == 2'b10)
        |-> ((next_addr[DISP_W-1:0] & $past(disp_status)) == $past(disp_status)));

    // R3: bits above the condition field always keep the base
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (next_addr[ADDR_W-1:DISP_W] == $past(next_field[ADDR_W-1:DISP_W])));

    // R5: an armed trap ORs its bit into the next address
    a_r5_pg_or: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pg_armed)) |-> next_addr[PCROSS_BIT]);

endmodule

// File: tb/tb_ums_microseq.sv
`timescale 1ns/1ps
module tb_ums_microseq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] next_field = '0;
    logic [1:0]  br_sel = 2'b00;
    logic        alu_zero = 1'b0;
    logic [1:0]  disp_status = 2'b00;
    logic        mar_load = 1'b0;
    logic        alu_carry8 = 1'b0;
    logic        mem_req = 1'b0;
    logic [11:0] next_addr;
    logic        abort_mem;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ums_microseq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .next_field  (next_field),
        .br_sel      (br_sel),
        .alu_zero    (alu_zero),
        .disp_status (disp_status),
        .mar_load    (mar_load),
        .alu_carry8  (alu_carry8),
        .mem_req     (mem_req),
        .next_addr   (next_addr),
        .abort_mem   (abort_mem)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] f, input logic [1:0] s, input logic z,
                         input logic [1:0] d, input logic ml, input logic cy, input logic mr);
        next_field  = f;
        br_sel      = s;
        alu_zero    = z;
        disp_status = d;
        mar_load    = ml;
        alu_carry8  = cy;
        mem_req     = mr;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        drive(12'hFFF, 2'b10, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R8 addr in reset", next_addr, 12'h000);
        chk("R8 abort in reset", abort_mem, 1'b0);
        rst_n = 1'b1;
        drive(12'h000, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_plain();
        drive(12'hABC, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R1 plain", next_addr, 12'hABC);
        drive(12'h7F0, 2'b00, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1);
        chk("R1 no abort", abort_mem, 1'b0);
        tick();
        chk("R1 zero/status ignored", next_addr, 12'h7F0);
        drive(12'h5A4, 2'b11, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R9 reserved select", next_addr, 12'h5A4);
    endtask

    task automatic t_zero();
        drive(12'h100, 2'b01, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R2 zero taken", next_addr, 12'h101);
        drive(12'h100, 2'b01, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R2 zero not taken", next_addr, 12'h100);
    endtask

    task automatic t_disp();
        for (int i = 0; i < 4; i++) begin
            drive(12'h00C, 2'b10, 1'b1, 2'(i), 1'b0, 1'b0, 1'b0);
            tick();
            chk("R3 dispatch", next_addr, 12'h00C + 12'(i));
        end
        drive(12'hF30, 2'b10, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
        tick();
        chk("R3 upper kept", next_addr, 12'hF32);
    endtask

    task automatic t_page();
        drive(12'h200, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        chk("R7 no abort on crossing instr", abort_mem, 1'b0);
        tick();
        chk("R7 own address unchanged", next_addr, 12'h200);
        drive(12'h300, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R4 abort", abort_mem, 1'b1);
        tick();
        chk("R5 or 2", next_addr, 12'h302);
        drive(12'h400, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R6 abort cleared", abort_mem, 1'b0);
        tick();
        chk("R6 or cleared", next_addr, 12'h400);
    endtask

    task automatic t_page_merge();
        drive(12'h080, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        tick();
        drive(12'h010, 2'b10, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        chk("R4 no abort without request", abort_mem, 1'b0);
        tick();
        chk("R5 with dispatch", next_addr, 12'h013);
        drive(12'h080, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        tick();
        drive(12'h020, 2'b01, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R4 abort", abort_mem, 1'b1);
        tick();
        chk("R5 with zero", next_addr, 12'h023);
    endtask

    task automatic t_no_cross();
        drive(12'h0F0, 2'b00, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        tick();
        drive(12'h0E0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R10 load without carry", abort_mem, 1'b0);
        tick();
        chk("R10 load without carry addr", next_addr, 12'h0E0);
        drive(12'h0D0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        tick();
        drive(12'h0C0, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R10 carry without load", abort_mem, 1'b0);
        tick();
        chk("R10 carry without load addr", next_addr, 12'h0C0);
    endtask

    task automatic t_chain();
        drive(12'h600, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        tick();
        drive(12'h610, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R4 chain abort 1", abort_mem, 1'b1);
        tick();
        chk("R5 chain or 1", next_addr, 12'h612);
        drive(12'h620, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R6 rearmed abort", abort_mem, 1'b1);
        tick();
        chk("R6 rearmed or", next_addr, 12'h622);
        drive(12'h630, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R6 chain end abort", abort_mem, 1'b0);
        tick();
        chk("R6 chain end addr", next_addr, 12'h630);
    endtask

    task automatic t_mid_reset();
        drive(12'h700, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        tick();
        rst_n = 1'b0;
        drive(12'h700, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R8 async clear addr", next_addr, 12'h000);
        chk("R8 pending dropped", abort_mem, 1'b0);
        tick();
        rst_n = 1'b1;
        drive(12'h055, 2'b00, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R8 no abort after reset", abort_mem, 1'b0);
        tick();
        chk("R8 no or after reset", next_addr, 12'h055);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_plain();
        t_zero();
        t_disp();
        t_page();
        t_page_merge();
        t_no_cross();
        t_chain();
        t_mid_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule